// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Registers and Busy Timing

This block sits beside a 32-bit integer pipeline and executes its multiply and divide commands. A command carries an operation code and two 32-bit operands. A multiply leaves a 64-bit product split across the LO word (low half) and the HI word (high half). A divide leaves the quotient in LO and the remainder in HI. The pipeline can also load HI or LO directly, and it reads either word back through a read port.

The arithmetic is resolved when the command is accepted, and the result is written into HI/LO at that clock edge. A busy counter is then loaded with the latency of the operation, and any read request made while the counter is non-zero is held off by a stall output. Multiply latency depends on the magnitude of the first operand: small operands finish early. Divide latency is fixed. A divide by zero, and the one signed quotient that cannot be represented, produce fixed results and never trap.

Top module: `muldiv_unit`

## Requirements
- R1: A multiply (cmd_op 2'b00 signed, 2'b01 unsigned) writes the low 32 bits of the full 64-bit product to LO and the high 32 bits to HI, with the operands treated as two's complement for the signed form.
- R2: A divide (cmd_op 2'b10 signed, 2'b11 unsigned) with a non-zero divisor writes the quotient to LO and the remainder to HI. The signed form truncates toward zero, and the remainder takes the sign of the dividend.
- R3: An unsigned divide by zero writes all ones to LO and the dividend to HI.
- R4: A signed divide by zero writes the dividend to HI. LO becomes all ones for a dividend with bit 31 clear and 32'h1 for a dividend with bit 31 set.
- R5: A signed divide of 32'h80000000 by 32'hFFFFFFFF writes 32'h80000000 to LO and 0 to HI.
- R6: An unsigned multiply keeps the unit busy for 7, 11 or 15 cycles. With z the leading-zero count of (a | 1), the count is 7 + 4*(2 - z/11) under integer division. Equivalently: 7 when a < 2^10, 11 when a < 2^21, and 15 otherwise.
- R7: A signed multiply uses the same formula, with z taken from ((a XOR (a >>> 21)) | 1). This gives 7, 11 or 15 cycles, according to whether the bits of a that differ from its sign bit lie below position 10, below position 21, or higher.
- R8: Both divide forms keep the unit busy for 37 cycles.
- R9: rd_stall is high exactly while rd_req is high and the unit is busy. A read issued in the cycle after a command stalls for exactly the latency of that command, and rd_data then shows the result (rd_sel 0 selects LO, 1 selects HI). With rd_req low, rd_stall stays low even while busy.
- R10: A direct write (wr_lo_en or wr_hi_en) updates its word at the next clock edge, also while the unit is busy, and does not change the busy count.
- R11: A command accepted while the unit is busy reloads the busy counter with the new latency and replaces HI and LO with the new result.
- R12: After reset, HI and LO are zero, busy is low and rd_stall is low.
- R13: When a command and a direct write fall in the same cycle, the command result wins for both words. HI and LO hold their values in any cycle that has neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Accept a multiply/divide command this cycle |
| cmd_op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| cmd_a | input | 32 | First operand (multiplicand or dividend) |
| cmd_b | input | 32 | Second operand (multiplier or divisor) |
| wr_hi_en | input | 1 | Load HI from wr_data |
| wr_lo_en | input | 1 | Load LO from wr_data |
| wr_data | input | 32 | Data for direct writes |
| rd_req | input | 1 | Read request for the word chosen by rd_sel |
| rd_sel | input | 1 | 0 reads LO, 1 reads HI |
| rd_data | output | 32 | Selected word |
| rd_stall | output | 1 | Read must be held: unit still busy |
| busy | output | 1 | Busy counter non-zero |

## Verification
A wrong result latched at command time stays in HI or LO until the next command or direct write. It therefore shows on rd_data as soon as the stall clears, so every sweep point reads both words right after its busy window. A busy counter loaded with the wrong value, or counting at the wrong rate, shows as a stall length differing from 7, 11, 15 or 37 cycles in that same read. A mistake in the operand-magnitude bands or the restart logic appears at the first operand that crosses a band edge, or at the first command issued while busy. The sweep places operands on both sides of each band edge and on each special divide case.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;

  localparam int XLEN = 32;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } mdu_op_e;

  typedef struct packed {
    word_t hi;
    word_t lo;
  } hilo_t;

  // Count of zero bits above the highest set bit.
  function automatic int unsigned lead_zeros(word_t v);
    int unsigned n;
    logic seen;
    n = 0;
    seen = 1'b0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (!seen && !v[i]) n++;
      else seen = 1'b1;
    end
    return n;
  endfunction

  // Full double-width product split into HI/LO.
  function automatic hilo_t mul_result(word_t a, word_t b, logic sgn);
    logic [2*XLEN-1:0] p;
    hilo_t r;
    if (sgn)
      p = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
    else
      p = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    r.lo = p[XLEN-1:0];
    r.hi = p[2*XLEN-1:XLEN];
    return r;
  endfunction

  function automatic hilo_t divu_result(word_t a, word_t b);
    hilo_t r;
    if (b == '0) begin
      r.lo = '1;
      r.hi = a;
    end else begin
      r.lo = a / b;
      r.hi = a % b;
    end
    return r;
  endfunction

  function automatic hilo_t divs_result(word_t a, word_t b);
    hilo_t r;
    logic signed [XLEN-1:0] sa;
    logic signed [XLEN-1:0] sb;
    word_t min_neg;
    sa = a;
    sb = b;
    min_neg = {1'b1, {(XLEN-1){1'b0}}};
    if (b == '0) begin
      r.hi = a;
      r.lo = a[XLEN-1] ? word_t'(1) : '1;
    end else if (a == min_neg && b == '1) begin
      r.lo = min_neg;
      r.hi = '0;
    end else begin
      r.lo = word_t'(sa / sb);
      r.hi = word_t'(sa % sb);
    end
    return r;
  endfunction

endpackage

// File: rtl/mdu_datapath.sv
`timescale 1ns/1ps
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int DIV_CYCLES = 37,
  parameter int MUL_BASE   = 7,
  parameter int MUL_STEP   = 4,
  parameter int LZ_BAND    = 11,
  parameter int SIGN_SHIFT = 21,
  parameter int CNT_W      = 6
) (
  input  logic [1:0]       op,
  input  word_t            a,
  input  word_t            b,
  output hilo_t            res,
  output logic [CNT_W-1:0] lat
);

  mdu_op_e     op_e;
  word_t       mag_src;
  int unsigned lz;
  int unsigned mul_lat;

  assign op_e = mdu_op_e'(op);

  // Signed form folds the sign away so that only differing bits count.
  assign mag_src = (op_e == OP_MULS)
                   ? ((a ^ word_t'($signed(a) >>> SIGN_SHIFT)) | word_t'(1))
                   : (a | word_t'(1));
  assign lz      = lead_zeros(mag_src);
  assign mul_lat = MUL_BASE + MUL_STEP * (2 - lz / LZ_BAND);

  always_comb begin
    unique case (op_e)
      OP_MULS: begin res = mul_result(a, b, 1'b1); lat = CNT_W'(mul_lat);    end
      OP_MULU: begin res = mul_result(a, b, 1'b0); lat = CNT_W'(mul_lat);    end
      OP_DIVS: begin res = divs_result(a, b);      lat = CNT_W'(DIV_CYCLES); end
      default: begin res = divu_result(a, b);      lat = CNT_W'(DIV_CYCLES); end
    endcase
  end

endmodule

// File: rtl/mdu_busy_timer.sv
`timescale 1ns/1ps
module mdu_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             busy
);

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (busy)   cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/mdu_hilo_file.sv
`timescale 1ns/1ps
module mdu_hilo_file
  import mdu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_wr,
  input  hilo_t cmd_res,
  input  logic  wr_hi_en,
  input  logic  wr_lo_en,
  input  word_t wr_data,
  output word_t hi_q,
  output word_t lo_q
);

  localparam int NWORDS = 2;

  logic [NWORDS-1:0][XLEN-1:0] regs;

  // Index 0 is LO, index 1 is HI; a command outranks a direct write.
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic  dir_en;
    word_t cmd_val;
    assign dir_en  = (g == 0) ? wr_lo_en : wr_hi_en;
    assign cmd_val = (g == 0) ? cmd_res.lo : cmd_res.hi;
    always_ff @(posedge clk) begin
      if (!rst_n)      regs[g] <= '0;
      else if (cmd_wr) regs[g] <= cmd_val;
      else if (dir_en) regs[g] <= wr_data;
    end
  end

  assign lo_q = regs[0];
  assign hi_q = regs[1];

endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int DIV_CYCLES = 37,
  parameter int MUL_BASE   = 7,
  parameter int MUL_STEP   = 4,
  parameter int LZ_BAND    = 11,
  parameter int SIGN_SHIFT = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [31:0] cmd_a,
  input  logic [31:0] cmd_b,
  input  logic        wr_hi_en,
  input  logic        wr_lo_en,
  input  logic [31:0] wr_data,
  input  logic        rd_req,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        rd_stall,
  output logic        busy
);

  localparam int MUL_MAX = MUL_BASE + 2 * MUL_STEP;
  localparam int MAX_LAT = (DIV_CYCLES > MUL_MAX) ? DIV_CYCLES : MUL_MAX;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  hilo_t            cmd_res;
  logic [CNT_W-1:0] cmd_lat;
  logic [CNT_W-1:0] cnt_q;
  word_t            hi_q;
  word_t            lo_q;

  mdu_datapath #(
    .DIV_CYCLES(DIV_CYCLES), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP),
    .LZ_BAND(LZ_BAND), .SIGN_SHIFT(SIGN_SHIFT), .CNT_W(CNT_W)
  ) u_dp (
    .op  (cmd_op),
    .a   (cmd_a),
    .b   (cmd_b),
    .res (cmd_res),
    .lat (cmd_lat)
  );

  mdu_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_valid),
    .load_val (cmd_lat),
    .cnt_q    (cnt_q),
    .busy     (busy)
  );

  mdu_hilo_file u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_valid),
    .cmd_res  (cmd_res),
    .wr_hi_en (wr_hi_en),
    .wr_lo_en (wr_lo_en),
    .wr_data  (wr_data),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
  );

  assign rd_data  = rd_sel ? hi_q : lo_q;
  assign rd_stall = rd_req & busy;

endmodule

// File: rtl/muldiv_unit_chk.sv
`timescale 1ns/1ps
module muldiv_unit_chk #(
  parameter int CNT_W      = 6,
  parameter int DIV_CYCLES = 37,
  parameter int MUL_BASE   = 7,
  parameter int MUL_STEP   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_is_div,
  input logic             wr_hi_en,
  input logic             wr_lo_en,
  input logic [31:0]      wr_data,
  input logic             rd_req,
  input logic             rd_stall,
  input logic             busy,
  input logic [31:0]      hi_q,
  input logic [31:0]      lo_q,
  input logic [CNT_W-1:0] cnt_q
);

  a_r8_div_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_is_div |=> cnt_q == CNT_W'(DIV_CYCLES));

  a_r6_mul_band: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_is_div |=> (cnt_q == CNT_W'(MUL_BASE) ||
                                  cnt_q == CNT_W'(MUL_BASE + MUL_STEP) ||
                                  cnt_q == CNT_W'(MUL_BASE + 2 * MUL_STEP)));

  a_r11_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && busy |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !busy |=> !busy);

  a_r9_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && busy |-> rd_stall);

  a_r9_no_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req || !busy |-> !rd_stall);

  a_r10_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_en && !cmd_valid |=> lo_q == $past(wr_data));

  a_r10_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_en && !cmd_valid |=> hi_q == $past(wr_data));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !wr_hi_en && !wr_lo_en |=> $stable(hi_q) && $stable(lo_q));

endmodule

bind muldiv_unit muldiv_unit_chk #(
  .CNT_W(CNT_W), .DIV_CYCLES(DIV_CYCLES), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_is_div (cmd_op[1]),
  .wr_hi_en   (wr_hi_en),
  .wr_lo_en   (wr_lo_en),
  .wr_data    (wr_data),
  .rd_req     (rd_req),
  .rd_stall   (rd_stall),
  .busy       (busy),
  .hi_q       (hi_q),
  .lo_q       (lo_q),
  .cnt_q      (cnt_q)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [31:0] cmd_a = '0;
  logic [31:0] cmd_b = '0;
  logic        wr_hi_en = 1'b0;
  logic        wr_lo_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        rd_stall;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  muldiv_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
    .wr_data(wr_data), .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data),
    .rd_stall(rd_stall), .busy(busy)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {HI, LO} from plain integer arithmetic.
  function automatic logic [63:0] model(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb, p;
    int ia, ib;
    logic [63:0] up;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ia = a;
    ib = b;
    case (op)
      2'b00: begin p = sa * sb; return p; end
      2'b01: begin up = {32'h0, a} * {32'h0, b}; return up; end
      2'b10: begin
        if (b == 0) return {a, (ia < 0) ? 32'h1 : 32'hFFFF_FFFF};
        if (a == 32'h8000_0000 && ib == -1) return {32'h0, 32'h8000_0000};
        return {32'(ia % ib), 32'(ia / ib)};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic int model_lat(logic [1:0] op, logic [31:0] a);
    logic [31:0] m;
    if (op[1]) return 37;
    m = (op == 2'b00 && a[31]) ? ~a : a;
    if (m < 32'd1024) return 7;
    if (m < 32'h0020_0000) return 11;
    return 15;
  endfunction

  function automatic string res_tag(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    if (!op[1]) return "R1";
    if (b == 0) return (op == 2'b11) ? "R3" : "R4";
    if (op == 2'b10 && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R5";
    return "R2";
  endfunction

  task automatic send(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_a = a;
    cmd_b = b;
  endtask

  // Next cycle: drop command and writes, read LO, count stall cycles, then read HI.
  task automatic collect(output int n, output logic [31:0] lo, output logic [31:0] hi);
    @(negedge clk);
    cmd_valid = 1'b0;
    wr_hi_en = 1'b0;
    wr_lo_en = 1'b0;
    rd_req = 1'b1;
    rd_sel = 1'b0;
    #1;
    n = 0;
    while (rd_stall) begin
      n++;
      @(negedge clk);
      #1;
    end
    lo = rd_data;
    rd_sel = 1'b1;
    #0.5;
    hi = rd_data;
    rd_req = 1'b0;
    rd_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] vals [15];
    logic [63:0] e;
    logic [31:0] lo, hi;
    int n;
    vals = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h3FF, 32'h400, 32'h1F_FFFF, 32'h20_0000,
             32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FC00,
             32'hFFE0_0000, 32'h1234_5678, 32'hDEAD_BEEF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 lo", rd_data, 32'h0);
    rd_sel = 1'b1;
    #0.5;
    chk("R12 hi", rd_data, 32'h0);
    chk("R12 busy", {31'h0, busy}, 32'h0);
    rd_req = 1'b1;
    #0.5;
    chk("R12 stall", {31'h0, rd_stall}, 32'h0);
    rd_req = 1'b0;
    rd_sel = 1'b0;

    // Sweep: every op over every operand pair (R1..R8, R9 stall length)
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 15; i++) begin
        for (int j = 0; j < 15; j++) begin
          send(2'(op), vals[i], vals[j]);
          collect(n, lo, hi);
          e = model(2'(op), vals[i], vals[j]);
          chk({res_tag(2'(op), vals[i], vals[j]), " lo"}, lo, e[31:0]);
          chk({res_tag(2'(op), vals[i], vals[j]), " hi"}, hi, e[63:32]);
          chk(op[1] ? "R8 R9 stall" : (op == 0 ? "R7 R9 stall" : "R6 R9 stall"),
              32'(n), 32'(model_lat(2'(op), vals[i])));
        end
      end
    end

    // R9: busy without a read request raises no stall
    send(2'b11, 32'd9, 32'd2);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    chk("R9 busy", {31'h0, busy}, 32'h1);
    chk("R9 no req no stall", {31'h0, rd_stall}, 32'h0);
    repeat (40) @(negedge clk);

    // R11: restart while busy with a long multiply pending
    send(2'b01, 32'hFFFF_FFFF, 32'h2);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = 2'b11;
    cmd_a = 32'd100;
    cmd_b = 32'd7;
    collect(n, lo, hi);
    chk("R11 restart stall", 32'(n), 32'd37);
    chk("R11 lo", lo, 32'd14);
    chk("R11 hi", hi, 32'd2);

    // R10: direct write while idle
    @(negedge clk);
    wr_lo_en = 1'b1;
    wr_data = 32'hA5A5_0F0F;
    @(negedge clk);
    wr_lo_en = 1'b0;
    #1;
    chk("R10 lo idle", rd_data, 32'hA5A5_0F0F);

    // R10: direct write to HI while busy, busy count unchanged
    send(2'b10, 32'hFFFF_FF9C, 32'd7);
    @(negedge clk);
    cmd_valid = 1'b0;
    wr_hi_en = 1'b1;
    wr_data = 32'h0000_0055;
    collect(n, lo, hi);
    chk("R10 stall kept", 32'(n), 32'd36);
    chk("R10 hi busy write", hi, 32'h0000_0055);
    chk("R10 lo quotient", lo, 32'hFFFF_FFF2);

    // R13: command and direct write in the same cycle
    send(2'b01, 32'd3, 32'd5);
    wr_lo_en = 1'b1;
    wr_hi_en = 1'b1;
    wr_data = 32'hDEAD_0000;
    collect(n, lo, hi);
    chk("R13 lo cmd wins", lo, 32'd15);
    chk("R13 hi cmd wins", hi, 32'd0);
    chk("R13 R6 stall", 32'(n), 32'd7);

    // R13: idle cycles leave both words held
    repeat (5) @(negedge clk);
    #1;
    chk("R13 hold lo", rd_data, 32'd15);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule